// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits behind the asynchronous byte-wide bus of a parallel NOR flash and interprets command writes. A write cycle lasts while chip enable and write enable are both low. The address and data present during the cycle are held, and the command takes effect when either enable rises. The block keeps a persistent read mode: array, status or signature. It runs the two-cycle program and block-erase sequences and passes each confirmed operation to a program/erase controller as a one-cycle start pulse with an opcode, an address and a data byte.

The block also produces the erase-suspend and erase-resume requests. It owns the error and suspend bits of the status byte. The controller's busy level supplies the ready bit. The read-source select tells the datapath which source drives the bus. The signature code is formed from the live address. Power-down and supply lockout arrive as digital flags.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write of FFh selects array mode (rd_sel 0), 70h selects status mode (rd_sel 1) and 90h selects signature mode (rd_sel 2). The mode persists across any number of reads. Reset leaves array mode.
- R2: sig_code is 20h when addr bit 0 is low. When addr bit 0 is high it is F6h if TOP_BOOT is 1 and FEh if TOP_BOOT is 0. All other address bits are ignored.
- R3: 40h or 10h followed by any write gives a one-cycle op_start with op_code 0, and with op_addr and op_data taken from the second write. It also selects status mode.
- R4: 20h followed by D0h gives a one-cycle op_start with op_code 1, with op_addr taken from the D0h write. It also selects status mode.
- R5: If the write after 20h is not D0h, status bits 5 and 4 are set, no operation starts, and status mode is selected.
- R6: 50h clears status bits 5 and 4.
- R7: B0h while pec_busy is high and no erase is suspended gives a one-cycle susp_req, sets status bit 6 and selects status mode. In any other situation B0h is ignored.
- R8: D0h written while suspended gives a one-cycle resume_req, clears bit 6 and selects status mode.
- R9: A set-up byte (40h, 10h or 20h) written while suspended, or while pec_busy is high, is ignored. The next write is then decoded as a command.
- R10: pd_n low or vcc_lock high returns the block to array mode, drops a pending set-up and clears suspend. Writes are ignored during that time.
- R11: 00h and undefined bytes leave the mode and the status unchanged.
- R12: A command uses the data present in the last cycle with both enables low. It takes effect when either enable rises, whether the write is controlled by we_n or by ce_n.
- R13: Status bit 7 equals the inverse of pec_busy. Bits 3 to 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| pd_n | input | 1 | Deep power-down, active low |
| vcc_lock | input | 1 | Supply lockout flag |
| addr | input | AW | Bus address |
| din | input | 8 | Bus write data |
| pec_busy | input | 1 | Controller busy level |
| rd_sel | output | 2 | Read source: 0 array, 1 status, 2 signature |
| sig_code | output | 8 | Signature byte for the current address |
| status_byte | output | 8 | Status register value |
| op_start | output | 1 | One-cycle operation start |
| op_code | output | 1 | 0 program, 1 erase |
| op_addr | output | AW | Operation address |
| op_data | output | 8 | Program data |
| susp_req | output | 1 | Erase-suspend request pulse |
| resume_req | output | 1 | Erase-resume request pulse |

## Verification
The assertions assume that each bus write holds both enables low for at least one clock. They also assume that pec_busy, pd_n and vcc_lock change only between writes and never within the cycle where a write completes. The bench drives every input on the falling clock edge and lets a write complete only when both enables are released. It changes pec_busy only between write tasks. Random command streams are drawn from the defined codes mixed with arbitrary bytes, so that undefined values and failed confirms are also exercised.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW = 19,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          pd_n,
  input  logic          vcc_lock,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic          pec_busy,
  output logic [1:0]    rd_sel,
  output logic [7:0]    sig_code,
  output logic [7:0]    status_byte,
  output logic          op_start,
  output logic          op_code,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data,
  output logic          susp_req,
  output logic          resume_req
);
  localparam logic [1:0] M_ARR = 2'd0, M_STS = 2'd1, M_SIG = 2'd2;
  localparam logic [1:0] P_IDLE = 2'd0, P_PGM = 2'd1, P_ERS = 2'd2;
  localparam logic [7:0] DEV_CODE = TOP_BOOT ? 8'hF6 : 8'hFE;

  logic [1:0]    mode, phase;
  logic          wr_q, susp, eerr, perr;
  logic [AW-1:0] a_l;
  logic [7:0]    d_l;

  wire off    = !pd_n || vcc_lock;
  wire wr_act = !ce_n && !we_n && !off;
  wire wr_end = wr_q && !wr_act;
  wire can_op = !susp && !pec_busy;

  assign rd_sel      = mode;
  assign sig_code    = addr[0] ? DEV_CODE : 8'h20;
  assign status_byte = {!pec_busy, susp, eerr, perr, 4'h0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_ARR; phase <= P_IDLE; wr_q <= 1'b0;
      susp <= 1'b0; eerr <= 1'b0; perr <= 1'b0;
      a_l <= '0; d_l <= '0;
      op_start <= 1'b0; op_code <= 1'b0; op_addr <= '0; op_data <= '0;
      susp_req <= 1'b0; resume_req <= 1'b0;
    end else begin
      op_start <= 1'b0; susp_req <= 1'b0; resume_req <= 1'b0;
      wr_q <= wr_act;
      if (wr_act) begin a_l <= addr; d_l <= din; end
      if (off) begin
        mode <= M_ARR; phase <= P_IDLE; susp <= 1'b0; wr_q <= 1'b0;
      end else if (wr_end) begin
        phase <= P_IDLE;
        case (phase)
          P_PGM: begin
            op_start <= 1'b1; op_code <= 1'b0; op_addr <= a_l; op_data <= d_l;
            mode <= M_STS;
          end
          P_ERS: begin
            mode <= M_STS;
            if (d_l == 8'hD0) begin
              op_start <= 1'b1; op_code <= 1'b1; op_addr <= a_l; op_data <= d_l;
            end else begin
              eerr <= 1'b1; perr <= 1'b1;
            end
          end
          default: begin
            case (d_l)
              8'hFF: mode <= M_ARR;
              8'h70: mode <= M_STS;
              8'h90: mode <= M_SIG;
              8'h50: begin eerr <= 1'b0; perr <= 1'b0; end
              8'h40, 8'h10: if (can_op) phase <= P_PGM;
              8'h20: if (can_op) phase <= P_ERS;
              8'hB0: if (pec_busy && !susp) begin
                susp <= 1'b1; susp_req <= 1'b1; mode <= M_STS;
              end
              8'hD0: if (susp) begin
                susp <= 1'b0; resume_req <= 1'b1; mode <= M_STS;
              end
              default: ;
            endcase
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int AW = 19
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pd_n,
  input logic       vcc_lock,
  input logic       pec_busy,
  input logic [1:0] rd_sel,
  input logic [7:0] status_byte,
  input logic       op_start,
  input logic       susp_req,
  input logic       resume_req
);
  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);
  p_start_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> rd_sel == 2'd1);
  p_susp_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    susp_req |-> status_byte[6] && $past(pec_busy) && !$past(status_byte[6]));
  p_resume_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> !status_byte[6] && $past(status_byte[6]));
  p_no_start_susp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> !$past(status_byte[6]));
  p_off_array_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_n || vcc_lock) |=> rd_sel == 2'd0 && !status_byte[6]);
  p_ready_bit_r13: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[7] == !pec_busy && status_byte[3:0] == 4'h0);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .vcc_lock(vcc_lock),
  .pec_busy(pec_busy), .rd_sel(rd_sel), .status_byte(status_byte),
  .op_start(op_start), .susp_req(susp_req), .resume_req(resume_req));

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
  localparam int AW = 19;
  logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, pd_n = 1, vcc_lock = 0, pec_busy = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [1:0] rd_sel;
  logic [7:0] sig_code, status_byte, op_data;
  logic op_start, op_code, susp_req, resume_req;
  logic [AW-1:0] op_addr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_cmd_decoder #(.AW(AW), .TOP_BOOT(1'b0)) dut (.*);

  // bench model state
  int m_mode = 0, m_phase = 0;
  bit m_susp = 0, m_eerr = 0, m_perr = 0;
  bit x_start, x_code, x_sreq, x_rreq;
  logic [AW-1:0] x_addr;
  logic [7:0] x_data;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {!pec_busy, m_susp, m_eerr, m_perr, 4'h0};
  endfunction

  function automatic logic [7:0] exp_sig(logic a0);
    return a0 ? 8'hFE : 8'h20;
  endfunction

  task automatic model(logic [AW-1:0] a, logic [7:0] d);
    x_start = 0; x_sreq = 0; x_rreq = 0;
    if (m_phase == 1) begin
      x_start = 1; x_code = 0; x_addr = a; x_data = d; m_mode = 1; m_phase = 0;
    end else if (m_phase == 2) begin
      m_mode = 1; m_phase = 0;
      if (d == 8'hD0) begin x_start = 1; x_code = 1; x_addr = a; end
      else begin m_eerr = 1; m_perr = 1; end
    end else begin
      case (d)
        8'hFF: m_mode = 0;
        8'h70: m_mode = 1;
        8'h90: m_mode = 2;
        8'h50: begin m_eerr = 0; m_perr = 0; end
        8'h40, 8'h10: if (!m_susp && !pec_busy) m_phase = 1;
        8'h20: if (!m_susp && !pec_busy) m_phase = 2;
        8'hB0: if (pec_busy && !m_susp) begin m_susp = 1; x_sreq = 1; m_mode = 1; end
        8'hD0: if (m_susp) begin m_susp = 0; x_rreq = 1; m_mode = 1; end
        default: ;
      endcase
    end
  endtask

  // we_n-controlled (ce_ctl=0) or ce_n-controlled write; returns at the sampling point
  task automatic bus_wr(logic [AW-1:0] a, logic [7:0] d, bit ce_ctl = 0);
    @(negedge clk);
    addr = a; din = d;
    if (ce_ctl) begin we_n = 0; @(negedge clk); ce_n = 0; end
    else begin ce_n = 0; we_n = 0; end
    @(negedge clk);
    if (ce_ctl) ce_n = 1; else we_n = 1;
    @(negedge clk);
    ce_n = 1; we_n = 1;
    model(a, d);
  endtask

  task automatic cmp(string r);
    chk({r, " rd_sel"}, rd_sel, m_mode);
    chk({r, " status"}, status_byte, exp_status());
    chk({r, " op_start"}, op_start, x_start);
    chk({r, " susp_req"}, susp_req, x_sreq);
    chk({r, " resume_req"}, resume_req, x_rreq);
    if (x_start) begin
      chk({r, " op_code"}, op_code, x_code);
      chk({r, " op_addr"}, op_addr, x_addr);
      if (!x_code) chk({r, " op_data"}, op_data, x_data);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset mode", rd_sel, 0);
    chk("R13 reset status", status_byte, 8'h80);

    bus_wr(19'h0, 8'h90); cmp("R1 sig");
    addr = 19'h7FFFE; #1 chk("R2 manuf", sig_code, 8'h20);
    addr = 19'h00001; #1 chk("R2 device", sig_code, 8'hFE);
    bus_wr(19'h0, 8'h70); cmp("R1 status");
    bus_wr(19'h0, 8'h00); cmp("R11 reserved");
    bus_wr(19'h0, 8'h5C); cmp("R11 undefined");
    bus_wr(19'h0, 8'hFF); cmp("R1 array");

    bus_wr(19'h0, 8'h40); cmp("R3 setup");
    bus_wr(19'h01234, 8'h5A); cmp("R3 program");
    bus_wr(19'h0, 8'h10, 1); cmp("R12 ce setup");
    bus_wr(19'h05555, 8'hA5, 1); cmp("R12 ce program");
    bus_wr(19'h0, 8'h20); cmp("R4 setup");
    bus_wr(19'h04000, 8'hD0); cmp("R4 erase");

    pec_busy = 1;
    bus_wr(19'h0, 8'h40); cmp("R9 busy setup");
    bus_wr(19'h0, 8'hFF); cmp("R9 busy next");
    bus_wr(19'h0, 8'hB0); cmp("R7 suspend");
    bus_wr(19'h0, 8'hB0); cmp("R7 repeat ignored");
    pec_busy = 0;
    bus_wr(19'h0, 8'h20); cmp("R9 susp setup");
    bus_wr(19'h0, 8'hFF); cmp("R9 susp next array");
    pec_busy = 1;
    bus_wr(19'h0, 8'hD0); cmp("R8 resume");
    pec_busy = 0;

    bus_wr(19'h0, 8'h20); cmp("R5 setup");
    bus_wr(19'h0, 8'h33); cmp("R5 bad confirm");
    chk("R5 bits", status_byte[5:4], 2'b11);
    pec_busy = 1; #1 chk("R13 busy bit", status_byte[7], 0); pec_busy = 0;
    bus_wr(19'h0, 8'h50); cmp("R6 clear");

    // R12: data changes within one write; last active value counts
    @(negedge clk); din = 8'hFF; ce_n = 0; we_n = 0;
    @(negedge clk); din = 8'h90;
    @(negedge clk); we_n = 1; ce_n = 1;
    @(negedge clk); model('0, 8'h90); cmp("R12 last data");

    // R10 power-down and lockout
    bus_wr(19'h0, 8'h20);
    @(negedge clk); pd_n = 0;
    ce_n = 0; we_n = 0; din = 8'h70;
    @(negedge clk); @(negedge clk); ce_n = 1; we_n = 1;
    @(negedge clk); pd_n = 1;
    m_mode = 0; m_phase = 0; m_susp = 0; x_start = 0; x_sreq = 0; x_rreq = 0;
    @(negedge clk); cmp("R10 power-down");
    bus_wr(19'h0, 8'hFF); cmp("R10 setup dropped");
    bus_wr(19'h0, 8'h70);
    @(negedge clk); vcc_lock = 1; @(negedge clk); vcc_lock = 0; m_mode = 0;
    @(negedge clk); cmp("R10 lockout");

    for (int i = 0; i < 400; i++) begin
      logic [7:0] d;
      int k;
      k = $urandom_range(0, 11);
      case (k)
        0: d = 8'hFF; 1: d = 8'h70; 2: d = 8'h90; 3: d = 8'h50;
        4: d = 8'h40; 5: d = 8'h10; 6: d = 8'h20; 7: d = 8'hB0;
        8: d = 8'hD0; 9: d = 8'h00;
        default: d = 8'($urandom);
      endcase
      if ($urandom_range(0, 3) == 0) pec_busy = ~pec_busy;
      bus_wr(19'($urandom), d, bit'($urandom_range(0, 1)));
      cmp("R3 R4 R5 R7 R8 R9 random");
      if (m_mode == 2) begin
        addr = 19'($urandom); #1 chk("R2 random sig", sig_code, exp_sig(addr[0]));
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule